// File: doc/BRIEF.md
# Asynchronous SRAM Lane-Select Controller

This block sits between a clocked host and an asynchronous static RAM of 32K words by 32 bits. The RAM is built from four byte-wide banks. The banks share one address bus, one active-low output enable and a 32-bit data bus. Each bank has its own active-low chip select and its own active-low write enable. The host issues one request at a time with a word address, write data, a read/write flag and a width code. The controller then turns the request into a timed sequence of bank strobes.

The width code chooses which banks take part. A full-word access strobes all four banks together. A half-word access strobes either the low pair or the high pair. A byte access strobes a single bank. Each access has fixed phases counted in clock cycles:

- A read has an access phase with output enable low, then a quiet turnaround. During the turnaround the banks release the bus.
- A write has a pulse with write enable low. The controller's own bus driver turns on only in the tail of that pulse. The driver holds for one cycle after write enable returns high.

The data bus is split at the boundary into an outbound value, a per-lane drive enable and an inbound value. The pad ring combines them into the bidirectional pins.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_done` is 0. All chip selects and write enables are high (4'hF), `mem_oe_n` is 1 and `mem_dq_oe` is 4'h0.
- R2: Lane `l` (0 to 3) carries data bits `8l+7:8l`. The width code selects the lanes as follows:
  - 2'b10 and 2'b11 select all four lanes.
  - 2'b01 selects lanes 0 and 1 when `req_lane[0]`=0, and lanes 2 and 3 when it is 1.
  - 2'b00 selects the single lane numbered by `req_lane[1:0]`.
  - Lanes outside the selection keep chip select and write enable high for the whole access.
- R3: A read accepted at a clock edge holds the selected chip selects low, `mem_oe_n` low and all write enables high. This lasts for the next RD_CYC cycles (default 5).
- R4: Read data is sampled from `mem_dq_i` on the last access cycle. It is returned on `rsp_rdata` in its lane positions, and unselected lanes read as zero.
- R5: After the read access phase, TURN_CYC cycles (default 2) follow with every strobe high, `mem_oe_n` high and no lane driven. Only then is the read complete.
- R6: A write accepted at a clock edge holds chip select and write enable low on the selected lanes for the next WR_CYC cycles (default 4). `mem_oe_n` stays high throughout.
- R7: During a write, `mem_dq_oe` turns on for the selected lanes only after write enable has been low for TURN_CYC cycles, and `mem_dq_o` then carries `req_wdata`. The enable stays on for exactly one cycle after the write enables return high, then turns off. Unselected lanes are never driven.
- R8: `rsp_done` is high for exactly one cycle. That cycle is the first idle cycle after a transaction: cycle RD_CYC+TURN_CYC+1 after a read is accepted, or WR_CYC+2 after a write. `rsp_rdata` is valid in that cycle.
- R9: `req_ready` is high only when the controller is idle. A request presented while it is low has no effect: no strobe changes and no later transaction starts from it.
- R10: `mem_addr` equals the accepted request's address throughout the access and is not altered by requests that are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Width code: 00 byte, 01 half-word, 1x full word |
| req_lane | input | 2 | Lane selector for byte and half-word accesses |
| req_addr | input | 15 | Word address |
| req_wdata | input | 32 | Write data in lane positions |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 15 | Shared RAM address |
| mem_cs_n | output | 4 | Per-bank chip select, active low |
| mem_we_n | output | 4 | Per-bank write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Outbound data toward the pads |
| mem_dq_oe | output | 4 | Per-lane pad drive enable |
| mem_dq_i | input | 32 | Inbound data from the pads |

## Verification
The assertions guard the following on every cycle:
- The bank strobes only ever form a legal group: all, a pair or one lane.
- A write enable never goes low outside its chip select.
- Output enable and write enable are never low together.
- The pad driver never turns on while the banks may still be driving, turns on only after a write enable is already low, and releases in the cycle after the write pulse ends.
- The completion pulse lasts one cycle and falls in an idle cycle.

Only the bench's scenarios can show the rest:
- Each phase has the right length.
- The right bytes land in the right banks under each width and lane choice.
- Unselected lanes read back as zero.
- A request made while busy leaves no trace.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_32X = 2'b11
  } width_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_TURN = 3'd2,
    PH_WR   = 3'd3,
    PH_REL  = 3'd4
  } phase_e;

  // Which byte lanes a request touches.
  function automatic logic [LANES-1:0] lane_mask(input width_e w, input logic [1:0] sel);
    logic [LANES-1:0] m;
    case (w)
      WID_8:   m = LANES'(1) << sel;
      WID_16:  m = sel[0] ? 4'b1100 : 4'b0011;
      default: m = '1;
    endcase
    return m;
  endfunction

  // Zero every lane outside the mask.
  function automatic logic [DATA_W-1:0] lane_keep(input logic [DATA_W-1:0] d,
                                                  input logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) r[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_lane_pkg::*;
(
  input  logic [1:0]       width,
  input  logic [1:0]       lane,
  output logic [LANES-1:0] mask
);

  always_comb begin
    mask = lane_mask(width_e'(width), lane);
    // R2: every request touches at least one lane
    a_mask_nonempty_r2: assert (mask != '0);
  end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC   = 5,
  parameter int WR_CYC   = 4,
  parameter int TURN_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  output phase_e phase,
  output logic   ph_last,
  output logic   wr_drive,
  output logic   idle,
  output logic   done
);

  localparam int MAXC  = (RD_CYC > WR_CYC) ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                           : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_FROM  = CNT_W'(TURN_CYC);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_comb begin
    case (ph_q)
      PH_RD:   ph_last = (cnt_q == RD_LAST);
      PH_TURN: ph_last = (cnt_q == TURN_LAST);
      PH_WR:   ph_last = (cnt_q == WR_LAST);
      PH_REL:  ph_last = 1'b1;
      default: ph_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= start_wr ? PH_WR : PH_RD;
          cnt_q <= '0;
        end
        PH_RD: if (ph_last) begin
          ph_q  <= PH_TURN;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_TURN: if (ph_last) begin
          ph_q   <= PH_IDLE;
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        PH_WR: if (ph_last) begin
          ph_q  <= PH_REL;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_REL: begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = ph_q;
  assign idle     = (ph_q == PH_IDLE);
  assign done     = done_q;
  assign wr_drive = ((ph_q == PH_WR) && (cnt_q >= DRV_FROM)) || (ph_q == PH_REL);

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: completion lands in an idle cycle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);
  // R9: a start leaves idle on the next cycle
  p_start_leaves_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle);

endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  phase_e            phase,
  input  logic              ph_last,
  input  logic              wr_drive,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rd_q;
  logic              in_rd;
  logic              in_wr;
  logic              rd_sample;

  assign in_rd     = (phase == PH_RD);
  assign in_wr     = (phase == PH_WR);
  assign rd_sample = in_rd && ph_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      if (rd_sample) rd_q <= lane_keep(mem_dq_i, mask_q);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_cs_n[l]  = ~((in_rd || in_wr) && mask_q[l]);
    assign mem_we_n[l]  = ~(in_wr && mask_q[l]);
    assign mem_dq_oe[l] = wr_drive && mask_q[l];
  end

  assign mem_oe_n = ~in_rd;
  assign mem_dq_o = wdata_q;
  assign mem_addr = addr_q;
  assign rd_data  = rd_q;

  // R2: strobes form one legal group
  p_group_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (~mem_cs_n) inside {4'h0, 4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8});
  // R6: a write enable is only low inside its chip select
  p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n | ~mem_cs_n) == 4'hF);
  // R6: output enable and write enable are never low together
  p_oe_excl_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n == 4'hF));
  // R5: no drive while outputs are or were just enabled
  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != 4'h0) |-> (mem_oe_n && $past(mem_oe_n)));
  // R7: driver turns on only after write enable is already low
  p_drive_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe != 4'h0) && ($past(mem_dq_oe) == 4'h0)) |-> ($past(mem_we_n) != 4'hF));
  // R7: driver still on in the cycle the write enables rise
  p_hold_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mem_we_n) != 4'hF) && (mem_we_n == 4'hF)) |-> (mem_dq_oe != 4'h0));
  // R7: driver off one cycle after the write pulse ends
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe != 4'h0) && (mem_we_n == 4'hF)) |=> (mem_dq_oe == 4'h0));
  // R10: address is steady while a bank stays selected
  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != 4'hF) && ($past(mem_cs_n) != 4'hF)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int RD_CYC   = 5,
  parameter int WR_CYC   = 4,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_width,
  input  logic [1:0]        req_lane,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic [LANES-1:0] req_mask;
  logic             accept;
  phase_e           phase;
  logic             ph_last;
  logic             wr_drive;
  logic             idle;

  assign accept    = req_valid && idle;
  assign req_ready = idle;

  sram_lane_decode u_decode (
    .width (req_width),
    .lane  (req_lane),
    .mask  (req_mask)
  );

  sram_phase_seq #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .phase    (phase),
    .ph_last  (ph_last),
    .wr_drive (wr_drive),
    .idle     (idle),
    .done     (rsp_done)
  );

  sram_lane_pins #(
    .ADDR_W (ADDR_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .phase     (phase),
    .ph_last   (ph_last),
    .wr_drive  (wr_drive),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rd_data   (rsp_rdata)
  );

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

  localparam int RDC = 5;
  localparam int WRC = 4;
  localparam int TNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_width = 2'b10;
  logic [1:0]  req_lane = 2'b00;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [14:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic [3:0]  mem_we_n;
  logic        mem_oe_n;
  logic [31:0] mem_dq_o;
  logic [3:0]  mem_dq_oe;
  logic [31:0] mem_dq_i;

  int checks = 0;
  int errors = 0;

  logic [7:0] mdl [4][16];
  logic [7:0] img [4][16];

  always #10 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_width(req_width), .req_lane(req_lane),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Bank model: drives a lane while read-enabled, else a junk pattern.
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      if (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l])
        mem_dq_i[l*8 +: 8] = mdl[l][mem_addr[3:0]];
      else
        mem_dq_i[l*8 +: 8] = 8'hEE;
    end
  end

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (!mem_cs_n[l] && !mem_we_n[l] && mem_dq_oe[l])
        mdl[l][mem_addr[3:0]] <= mem_dq_o[l*8 +: 8];
      if (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l] && mem_dq_oe[l]) begin
        checks++;
        errors++;
        $display("FAIL R5 bus contention lane %0d: actual=driven expected=released", l);
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] bench_mask(input logic [1:0] w, input logic [1:0] sel);
    logic [3:0] m;
    for (int l = 0; l < 4; l++) begin
      if (w == 2'b00)      m[l] = (l == int'(sel));
      else if (w == 2'b01) m[l] = ((l / 2) == int'(sel[0]));
      else                 m[l] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] expand(input logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
    return r;
  endfunction

  task automatic check_reset();
    chk("R1", "ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "done", {31'd0, rsp_done}, 32'd0);
    chk("R1", "cs_n/we_n", {24'd0, mem_cs_n, mem_we_n}, 32'hFF);
    chk("R1", "oe_n/dq_oe", {27'd0, mem_oe_n, mem_dq_oe}, 32'h10);
  endtask

  // Read with phase checks; optional ignored request while busy (R9, R10).
  task automatic do_read(input logic [14:0] a, input logic [1:0] w, input logic [1:0] sel, input bit inject);
    logic [3:0]  m;
    logic [31:0] exp;
    m = bench_mask(w, sel);
    for (int l = 0; l < 4; l++) exp[l*8 +: 8] = m[l] ? img[l][a[3:0]] : 8'h00;
    @(negedge clk);
    chk("R9", "ready before read", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = 1'b0; req_width = w; req_lane = sel; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= RDC + TNC + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= RDC) begin
        chk("R3", "read cs_n", {28'd0, mem_cs_n}, {28'd0, ~m});
        chk("R3", "read oe_n/we_n", {27'd0, mem_oe_n, mem_we_n}, 32'h0F);
        chk("R10", "read addr", {17'd0, mem_addr}, {17'd0, a});
        chk("R8", "done during read", {31'd0, rsp_done}, 32'd0);
      end else if (k <= RDC + TNC) begin
        chk("R5", "turn strobes", {23'd0, mem_oe_n, mem_cs_n, mem_we_n}, 32'h1FF);
        chk("R5", "turn drive", {28'd0, mem_dq_oe}, 32'd0);
        chk("R8", "done during turn", {31'd0, rsp_done}, 32'd0);
      end else if (k == RDC + TNC + 1) begin
        chk("R8", "done pulse", {31'd0, rsp_done}, 32'd1);
        chk("R4", "read data", rsp_rdata, exp);
        chk("R9", "ready at done", {31'd0, req_ready}, 32'd1);
      end else begin
        chk("R8", "done single", {31'd0, rsp_done}, 32'd0);
        chk("R9", "no stray access", {24'd0, mem_cs_n, mem_we_n}, 32'hFF);
      end
      if (inject && k == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_width = 2'b10;
        req_addr = a ^ 15'h0009; req_wdata = 32'hDEADBEEF;
      end
      if (inject && k >= 2 && k <= 4) begin
        chk("R9", "busy not ready", {31'd0, req_ready}, 32'd0);
        chk("R10", "addr held", {17'd0, mem_addr}, {17'd0, a});
      end
      if (inject && k == 4) req_valid = 1'b0;
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [1:0] w, input logic [1:0] sel, input logic [31:0] d);
    logic [3:0]  m;
    logic [31:0] dm;
    m  = bench_mask(w, sel);
    dm = expand(m);
    @(negedge clk);
    chk("R9", "ready before write", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = 1'b1; req_width = w; req_lane = sel; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int k = 1; k <= WRC + 3; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= WRC) begin
        chk("R6", "write cs_n", {28'd0, mem_cs_n}, {28'd0, ~m});
        chk("R6", "write we_n", {28'd0, mem_we_n}, {28'd0, ~m});
        chk("R6", "write oe_n", {31'd0, mem_oe_n}, 32'd1);
        chk("R10", "write addr", {17'd0, mem_addr}, {17'd0, a});
        chk("R7", "drive in pulse", {28'd0, mem_dq_oe}, (k > TNC) ? {28'd0, m} : 32'd0);
        if (k > TNC) chk("R7", "drive data", mem_dq_o & dm, d & dm);
      end else if (k == WRC + 1) begin
        chk("R7", "release strobes", {24'd0, mem_cs_n, mem_we_n}, 32'hFF);
        chk("R7", "hold drive", {28'd0, mem_dq_oe}, {28'd0, m});
        chk("R8", "done early", {31'd0, rsp_done}, 32'd0);
      end else if (k == WRC + 2) begin
        chk("R8", "write done", {31'd0, rsp_done}, 32'd1);
        chk("R7", "drive off", {28'd0, mem_dq_oe}, 32'd0);
      end else begin
        chk("R8", "write done single", {31'd0, rsp_done}, 32'd0);
      end
    end
    for (int l = 0; l < 4; l++) if (m[l]) img[l][a[3:0]] = d[l*8 +: 8];
  endtask

  task automatic run_all();
    for (int l = 0; l < 4; l++)
      for (int x = 0; x < 16; x++) begin
        mdl[l][x] = 8'(l * 16 + x + 8'h30);
        img[l][x] = 8'(l * 16 + x + 8'h30);
      end
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    do_read(15'h0003, 2'b10, 2'b00, 1'b0);
    do_write(15'h0005, 2'b10, 2'b00, 32'hA1B2C3D4);
    do_read(15'h0005, 2'b10, 2'b00, 1'b0);
    do_write(15'h0005, 2'b01, 2'b01, 32'h55667788);
    do_read(15'h0005, 2'b10, 2'b00, 1'b0);
    do_read(15'h0005, 2'b01, 2'b00, 1'b0);
    do_read(15'h0005, 2'b01, 2'b11, 1'b0);
    do_write(15'h0007, 2'b00, 2'b10, 32'h11223344);
    do_read(15'h0007, 2'b00, 2'b10, 1'b0);
    do_read(15'h0007, 2'b11, 2'b00, 1'b0);
    do_read(15'h7FF2, 2'b10, 2'b00, 1'b1);
    do_read(15'h000B, 2'b10, 2'b00, 1'b0);
    do_write(15'h000A, 2'b00, 2'b01, 32'hCAFE9A00);
    do_read(15'h000A, 2'b10, 2'b00, 1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule